// File: doc/BRIEF.md
# Fused-Idiom Integer Execution Unit

This block is a 64-bit integer execution unit for operations that a front end produces when it merges two dependent instructions into one. Each operation yields exactly what the original instruction pair would have left in the destination register: zero-extending a word and shifting it left, shifting right and then adding, keeping only the low bit, byte or half of a word sum or a logic result, and assembling a 32-bit constant from an upper and a lower immediate.

A caller presents an operation code, two 64-bit operands (the second may already hold an expanded immediate) and a 32-bit packed immediate for the constant-building operations. With the output register enabled, which is the default, the result and its valid flag appear one clock later. With it disabled, the unit is purely combinational.

Top module: `fuse_alu`

## Requirements
- R1: Operation code 0 returns src_a + src_b modulo 2^64. Operation codes are 5 bits wide.
- R2: Codes 1, 2 and 3 zero-extend src_a[31:0] and shift it left by 1, 2 and 3 respectively. This matches a left shift by 32 followed by a logical right shift by 31, 30 or 29.
- R3: Code 4 returns src_a[15:8] zero-extended to 64 bits.
- R4: Code 5 returns (src_a << 4) + src_b modulo 2^64.
- R5: Codes 6, 7, 8 and 9 return (src_a >> N) + src_b, where the shift is logical and N is 29, 30, 31 and 32 respectively.
- R6: Code 10 returns (src_a & 1) + src_b. Code 11 adds (src_a & 1) to src_b[31:0] in 32 bits and sign-extends bit 31 of that sum.
- R7: Code 12 returns {src_a[63:8], 8'h00} | src_b.
- R8: Codes 13 to 16 form the 32-bit sum src_a[31:0] + src_b[31:0] and return, in order: bit 0 only, bits 7:0 zero-extended, bits 15:0 zero-extended, bits 15:0 sign-extended.
- R9: Codes 17, 18, 19 and 20 compute src_a AND src_b, src_a OR src_b, src_a XOR src_b, or the byte-OR-combine of src_a, and return only bit 0 of that result.
- R10: Codes 21, 22, 23 and 24 apply the same four logic functions in the same order and return bits 15:0 zero-extended. The byte-OR-combine function sets each byte of the result to 8'hFF when any bit of that byte of src_a is set, and to 8'h00 otherwise.
- R11: The immediate is packed as imm[31:12] = upper part and imm[11:0] = lower part. Code 25 returns sext64({upper, 12'b0}) + sext64(lower). Code 26 returns that sum truncated to 32 bits and then sign-extended.
- R12: Codes 27 to 31 return zero.
- R13: With the output register enabled, out_valid and out_result show in_valid and the result of the inputs sampled at the previous rising edge. A clock edge with rst_n low clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the inputs as carrying an operation |
| op | input | 5 | Operation code |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand or expanded immediate |
| imm | input | 32 | Packed immediate {upper[19:0], lower[11:0]} |
| out_valid | output | 1 | Result valid flag |
| out_result | output | 64 | Operation result |

## Verification
Every one of the 32 operation codes is swept over all pairs drawn from a set of corner operands, plus random pairs. The corner set is zero, all-ones, 0x80000000, 0xFFFF, the top bit alone and 0x7FFFFFFFFFFFFFFF. The all-ones and 0x80000000 values separate the word forms from the 64-bit forms through carries and sign bits. 0xFFFF separates zero extension of a half from sign extension. Shift amounts that are off by one show up when high bits land at bit 32. The expected value comes from performing the two original instructions one after the other. A dedicated immediate with the upper part at 0x80000 and the lower part at -1 separates the 64-bit constant form from the word form. The valid flag alternates between operations so that the one-cycle latency can be checked.

// File: rtl/fuse_alu_pkg.sv
// Shared operation codes and helpers for the fused-idiom execution unit.
// Assumes a 64-bit datapath with 32-bit word operations.
package fuse_alu_pkg;
    localparam int XLEN   = 64;
    localparam int WLEN   = 32;
    localparam int OP_W   = 5;
    localparam int HALF_W = 16;

    typedef enum logic [OP_W-1:0] {
        OP_ADD       = 5'd0,
        OP_ZXW_SL1   = 5'd1,
        OP_ZXW_SL2   = 5'd2,
        OP_ZXW_SL3   = 5'd3,
        OP_BYTE1     = 5'd4,
        OP_SL4_ADD   = 5'd5,
        OP_SR29_ADD  = 5'd6,
        OP_SR30_ADD  = 5'd7,
        OP_SR31_ADD  = 5'd8,
        OP_SR32_ADD  = 5'd9,
        OP_ODD_ADD   = 5'd10,
        OP_ODD_ADDW  = 5'd11,
        OP_MASK_OR   = 5'd12,
        OP_ADDW_BIT  = 5'd13,
        OP_ADDW_BYTE = 5'd14,
        OP_ADDW_ZXH  = 5'd15,
        OP_ADDW_SXH  = 5'd16,
        OP_AND_LSB   = 5'd17,
        OP_OR_LSB    = 5'd18,
        OP_XOR_LSB   = 5'd19,
        OP_ORCB_LSB  = 5'd20,
        OP_AND_ZXH   = 5'd21,
        OP_OR_ZXH    = 5'd22,
        OP_XOR_ZXH   = 5'd23,
        OP_ORCB_ZXH  = 5'd24,
        OP_CONST     = 5'd25,
        OP_CONST_W   = 5'd26
    } fop_e;

    // Sign-extend a 32-bit word to the full width.
    function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] v);
        return {{(XLEN-WLEN){v[WLEN-1]}}, v};
    endfunction
endpackage

// File: rtl/fuse_arith_unit.sv
// Shift/extend/add group (codes 0..12). Returns zero for any other code.
// Purely combinational; assumes operands are already resolved.
module fuse_arith_unit
    import fuse_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] res
);
    localparam int WPAD = XLEN - WLEN;

    logic [XLEN-1:0] a_zxw;
    logic [WLEN-1:0] odd_sum_w;

    assign a_zxw     = {{WPAD{1'b0}}, src_a[WLEN-1:0]};
    assign odd_sum_w = {{(WLEN-1){1'b0}}, src_a[0]} + src_b[WLEN-1:0];

    // Select the result of the operation named by op.
    always_comb begin
        res = '0;
        case (op)
            OP_ADD:      res = src_a + src_b;
            OP_ZXW_SL1:  res = a_zxw << 1;
            OP_ZXW_SL2:  res = a_zxw << 2;
            OP_ZXW_SL3:  res = a_zxw << 3;
            OP_BYTE1:    res = {{(XLEN-8){1'b0}}, src_a[15:8]};
            OP_SL4_ADD:  res = (src_a << 4) + src_b;
            OP_SR29_ADD: res = (src_a >> 29) + src_b;
            OP_SR30_ADD: res = (src_a >> 30) + src_b;
            OP_SR31_ADD: res = (src_a >> 31) + src_b;
            OP_SR32_ADD: res = (src_a >> 32) + src_b;
            OP_ODD_ADD:  res = {{(XLEN-1){1'b0}}, src_a[0]} + src_b;
            OP_ODD_ADDW: res = sext_word(odd_sum_w);
            OP_MASK_OR:  res = {src_a[XLEN-1:8], 8'h00} | src_b;
            default:     res = '0;
        endcase
    end
endmodule

// File: rtl/fuse_narrow_unit.sv
// Narrowing group (codes 13..24). Only the low half of each operand can
// reach these results, so only that half is brought in. Zero for other codes.
module fuse_narrow_unit
    import fuse_alu_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [HALF_W-1:0] a_lo,
    input  logic [HALF_W-1:0] b_lo,
    output logic [XLEN-1:0]   res
);
    localparam int NBYTES = HALF_W / 8;

    logic [HALF_W-1:0] sum_lo;
    logic [HALF_W-1:0] orcb_lo;
    logic [HALF_W-1:0] logic_lo;

    assign sum_lo = a_lo + b_lo;

    // One byte-OR-combine lane per byte of the half.
    for (genvar g = 0; g < NBYTES; g++) begin : g_orcb
        assign orcb_lo[g*8 +: 8] = {8{|a_lo[g*8 +: 8]}};
    end

    // Pick the logic function; codes 17..20 and 21..24 share the order.
    always_comb begin
        case (op)
            OP_AND_LSB,  OP_AND_ZXH: logic_lo = a_lo & b_lo;
            OP_OR_LSB,   OP_OR_ZXH:  logic_lo = a_lo | b_lo;
            OP_XOR_LSB,  OP_XOR_ZXH: logic_lo = a_lo ^ b_lo;
            default:                 logic_lo = orcb_lo;
        endcase
    end

    // Narrow the word sum or the logic result as the code asks.
    always_comb begin
        res = '0;
        case (op)
            OP_ADDW_BIT:  res = {{(XLEN-1){1'b0}}, sum_lo[0]};
            OP_ADDW_BYTE: res = {{(XLEN-8){1'b0}}, sum_lo[7:0]};
            OP_ADDW_ZXH:  res = {{(XLEN-HALF_W){1'b0}}, sum_lo};
            OP_ADDW_SXH:  res = {{(XLEN-HALF_W){sum_lo[HALF_W-1]}}, sum_lo};
            OP_AND_LSB, OP_OR_LSB, OP_XOR_LSB, OP_ORCB_LSB:
                          res = {{(XLEN-1){1'b0}}, logic_lo[0]};
            OP_AND_ZXH, OP_OR_ZXH, OP_XOR_ZXH, OP_ORCB_ZXH:
                          res = {{(XLEN-HALF_W){1'b0}}, logic_lo};
            default:      res = '0;
        endcase
    end
endmodule

// File: rtl/fuse_const_unit.sv
// Constant assembly (codes 25, 26) from a packed {upper20, lower12} immediate.
// Zero for any other code.
module fuse_const_unit
    import fuse_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [WLEN-1:0] imm,
    output logic [XLEN-1:0] res
);
    localparam int LO_W = 12;

    logic [XLEN-1:0] upper_x;
    logic [XLEN-1:0] lower_x;
    logic [XLEN-1:0] full_sum;

    assign upper_x  = sext_word({imm[WLEN-1:LO_W], {LO_W{1'b0}}});
    assign lower_x  = {{(XLEN-LO_W){imm[LO_W-1]}}, imm[LO_W-1:0]};
    assign full_sum = upper_x + lower_x;

    // Full-width or word-truncated form.
    always_comb begin
        case (op)
            OP_CONST:   res = full_sum;
            OP_CONST_W: res = sext_word(full_sum[WLEN-1:0]);
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/fuse_alu.sv
// Top of the fused-idiom execution unit. The three operation groups each
// return zero outside their own codes, so their results are ORed together.
// REG_OUT=1 adds one register stage on the result and valid flag.
module fuse_alu
    import fuse_alu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [4:0]      op,
    input  logic [63:0]     src_a,
    input  logic [63:0]     src_b,
    input  logic [31:0]     imm,
    output logic            out_valid,
    output logic [63:0]     out_result
);
    logic [XLEN-1:0] arith_res;
    logic [XLEN-1:0] narrow_res;
    logic [XLEN-1:0] const_res;
    logic [XLEN-1:0] comb_res;

    fuse_arith_unit u_arith (
        .op    (op),
        .src_a (src_a),
        .src_b (src_b),
        .res   (arith_res)
    );

    fuse_narrow_unit u_narrow (
        .op   (op),
        .a_lo (src_a[HALF_W-1:0]),
        .b_lo (src_b[HALF_W-1:0]),
        .res  (narrow_res)
    );

    fuse_const_unit u_const (
        .op  (op),
        .imm (imm),
        .res (const_res)
    );

    assign comb_res = arith_res | narrow_res | const_res;

    if (REG_OUT) begin : g_reg
        // Capture result and valid; cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid  <= 1'b0;
                out_result <= '0;
            end else begin
                out_valid  <= in_valid;
                out_result <= comb_res;
            end
        end
    end else begin : g_comb
        assign out_valid  = in_valid;
        assign out_result = comb_res;
    end
endmodule

// File: rtl/fuse_alu_checker.sv
// Assertion checker for fuse_alu. It aligns the operation code with the
// result through its own register stage when the output register is on.
module fuse_alu_checker
    import fuse_alu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [4:0]  op,
    input logic        out_valid,
    input logic [63:0] out_result
);
    logic [4:0] q_op;
    logic       q_vld;
    logic       q_seen;
    logic [4:0] c_op;
    logic       c_vld;
    logic       live;

    // Remember the code and valid flag seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_op   <= '0;
            q_vld  <= 1'b0;
            q_seen <= 1'b0;
        end else begin
            q_op   <= op;
            q_vld  <= in_valid;
            q_seen <= 1'b1;
        end
    end

    assign c_op  = REG_OUT ? q_op  : op;
    assign c_vld = REG_OUT ? q_vld : in_valid;
    assign live  = REG_OUT ? q_seen : 1'b1;

    p_valid_follow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (out_valid == c_vld));

    p_unknown_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (live && c_op > OP_CONST_W) |-> (out_result == 64'd0));

    p_zxw_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && c_op >= OP_ZXW_SL1 && c_op <= OP_ZXW_SL3)
        |-> (out_result[63:35] == '0 && out_result[0] == 1'b0));

    p_byte_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && c_op == OP_BYTE1) |-> (out_result[63:8] == '0));

    p_single_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && c_op == OP_ADDW_BIT) |-> (out_result[63:1] == '0));

    p_half_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && c_op == OP_ADDW_SXH)
        |-> (out_result[63:16] == {48{out_result[15]}}));

    p_logic_lsb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live && c_op >= OP_AND_LSB && c_op <= OP_ORCB_LSB)
        |-> (out_result[63:1] == '0));

    p_logic_zxh_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live && c_op >= OP_AND_ZXH && c_op <= OP_ORCB_ZXH)
        |-> (out_result[63:16] == '0));
endmodule

bind fuse_alu fuse_alu_checker #(.REG_OUT(REG_OUT)) u_fuse_alu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/fuse_alu_bench.sv
// Sweep of every code over corner operand pairs and random pairs. Expected
// values replay the original two-instruction sequence step by step.
module fuse_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [31:0] imm = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fuse_alu #(.REG_OUT(1'b1)) u_fuse_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op         (op),
        .src_a      (src_a),
        .src_b      (src_b),
        .imm        (imm),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] sx12(input logic [11:0] v);
        return {{52{v[11]}}, v};
    endfunction

    function automatic logic [63:0] orc_bytes(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = (v[k*8 +: 8] != 8'h00) ? 8'hFF : 8'h00;
        return r;
    endfunction

    // Replay of the original instruction pair for each code.
    function automatic logic [63:0] ref_pair(input int code, input logic [63:0] a,
                                             input logic [63:0] b, input logic [31:0] im);
        logic [63:0] t;
        logic [31:0] w;
        case (code)
            0:  return a + b;
            1, 2, 3: begin t = a << 32; return t >> (32 - code); end
            4:  begin t = a >> 8; return t & 64'd255; end
            5:  begin t = a << 4; return t + b; end
            6, 7, 8, 9: begin t = a >> (code + 23); return t + b; end
            10: begin t = a & 64'd1; return t + b; end
            11: begin t = a & 64'd1; w = t[31:0] + b[31:0]; return sx32(w); end
            12: begin t = a & sx12(12'hF00); return t | b; end
            13, 14, 15, 16: begin
                w = a[31:0] + b[31:0];
                t = sx32(w);
                if (code == 13) return t & 64'd1;
                if (code == 14) return t & 64'd255;
                if (code == 15) return t & 64'hFFFF;
                return {{48{t[15]}}, t[15:0]};
            end
            17, 18, 19, 20, 21, 22, 23, 24: begin
                case ((code - 17) % 4)
                    0:       t = a & b;
                    1:       t = a | b;
                    2:       t = a ^ b;
                    default: t = orc_bytes(a);
                endcase
                if (code <= 20) return t & 64'd1;
                return t & 64'hFFFF;
            end
            25: begin t = sx32({im[31:12], 12'h000}); return t + sx12(im[11:0]); end
            26: begin t = sx32({im[31:12], 12'h000}); w = t[31:0] + im[31:0] - im[31:0] + sx12(im[11:0]) ; return sx32(w); end
            default: return 64'd0;
        endcase
    endfunction

    function automatic string req_of(input int code);
        if (code == 0)  return "R1";
        if (code <= 3)  return "R2";
        if (code == 4)  return "R3";
        if (code == 5)  return "R4";
        if (code <= 9)  return "R5";
        if (code <= 11) return "R6";
        if (code == 12) return "R7";
        if (code <= 16) return "R8";
        if (code <= 20) return "R9";
        if (code <= 24) return "R10";
        if (code <= 26) return "R11";
        return "R12";
    endfunction

    // Drive one operation, then check result and valid one cycle later (R13).
    task automatic apply(input int code, input logic [63:0] a, input logic [63:0] b,
                         input logic [31:0] im, input logic vld);
        logic [63:0] exp_r;
        @(negedge clk);
        op = code[4:0]; src_a = a; src_b = b; imm = im; in_valid = vld;
        exp_r = ref_pair(code, a, b, im);
        @(negedge clk);
        checks++;
        if (out_result !== exp_r) begin
            errors++;
            $display("FAIL %s code %0d a=%h b=%h imm=%h: actual %h expected %h",
                     req_of(code), code, a, b, im, out_result, exp_r);
        end
        checks++;
        if (out_valid !== vld) begin
            errors++;
            $display("FAIL R13 valid latency code %0d: actual %b expected %b",
                     code, out_valid, vld);
        end
    endtask

    logic [63:0] corners [6];
    logic        vtoggle = 1'b0;

    initial begin
        corners[0] = 64'd0;
        corners[1] = {64{1'b1}};
        corners[2] = 64'h0000_0000_8000_0000;
        corners[3] = 64'h0000_0000_0000_FFFF;
        corners[4] = 64'h8000_0000_0000_0000;
        corners[5] = 64'h7FFF_FFFF_FFFF_FFFF;

        // Reset state: outputs stay clear while rst_n is low (R13).
        in_valid = 1'b1; op = 5'd0; src_a = 64'd5; src_b = 64'd7;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== 64'd0) begin
            errors++;
            $display("FAIL R13 reset: actual valid=%b result=%h expected 0 and 0",
                     out_valid, out_result);
        end
        rst_n = 1'b1;

        for (int code = 0; code < 32; code++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    vtoggle = ~vtoggle;
                    apply(code, corners[i], corners[j],
                          corners[i][31:0] ^ {corners[j][11:0], corners[j][31:12]}, vtoggle);
                end
            end
            for (int r = 0; r < 20; r++) begin
                vtoggle = ~vtoggle;
                apply(code, {$urandom, $urandom}, {$urandom, $urandom}, $urandom, vtoggle);
            end
        end

        // Constant corner: upper 0x80000 with lower -1 splits the two forms (R11).
        apply(25, 64'd0, 64'd0, 32'h8000_0FFF, 1'b1);
        apply(26, 64'd0, 64'd0, 32'h8000_0FFF, 1'b1);
        apply(26, 64'd0, 64'd0, 32'h7FFF_F7FF, 1'b0);
        // Unused codes ignore non-zero operands (R12).
        apply(31, {64{1'b1}}, {64{1'b1}}, 32'hFFFF_FFFF, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule